// File: doc/BRIEF.md
# Dual Time-of-Day Alarm Matcher

This block watches a running clock and calendar and raises an alarm when the time reaches one of two programmed moments. The first alarm slot holds seconds, minutes, hours and a day-or-date target. The second slot holds minutes, hours and a day-or-date target, and can only fire at second 00. Bit 7 of every alarm register is a mask: a masked field takes no part in the comparison. Bit 6 of each day/date register picks what bits 5:0 are compared against: the day of the week or the date of the month. The comparison happens only on the cycle in which the timekeeper presents its once-per-second update strobe.

A hit sets a sticky flag, whatever the interrupt settings are. The host can clear a flag but cannot set one. One control bit chooses what the shared output pin does. In interrupt mode the pin is pulled low while an enabled flag is set. In the other mode the pin passes through an external square wave. The pin is modelled as an open-drain pull-low enable. The square-wave rate field is held in the control register and is driven out to the divider beside this block. All pins are plain control and status pins. Nothing here streams, so there is no valid/ready handshake.

Top module: `tod_alarm_pair`

## Requirements
- R1: With no field masked in alarm slot 1, a tick sets `alarm1_flag` only when seconds, minutes, hours (bits 6:0 compared as stored) and the day/date target all equal the presented time.
- R2: A mask bit (bit 7) of 1 removes its field from the comparison. Slot 1 with all four fields masked sets its flag on every tick.
- R3: Slot 2 (addresses 4 minutes, 5 hours, 6 day/date) fires only on a tick whose seconds equal 00. With all of its fields masked it fires once per minute.
- R4: In a day/date register, bit 6 = 1 compares bits 5:0 with the day of week. Bit 6 = 0 compares bits 5:0 with the date of the month.
- R5: Without `tick`, no change of the time inputs sets a flag.
- R6: A hit sets its flag whatever the values of the interrupt-mode bit and the enables.
- R7: A write to the status register (address 8) clears flag 1 when bit 0 is 0 and flag 2 when bit 1 is 0. A bit of 1 leaves the flag unchanged. A hit in the same cycle as a clearing write leaves the flag set.
- R8: With control bit 2 (interrupt mode) at 1, `irq_drive` is 1 exactly while (flag1 and control bit 0) or (flag2 and control bit 1).
- R9: With control bit 2 at 0, `irq_drive` is the inverse of `sqw_in`: the pin follows the square wave.
- R10: After reset both flags are 0, interrupt mode is 1, both enables are 0, `sqw_rate` is 2'b11 and `irq_drive` is 0.
- R11: `sqw_rate` equals bits 4:3 of the last value written to the control register (address 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Once-per-second update strobe, one cycle wide |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours byte bits 6:0 (mode, AM/PM, digits) |
| now_wday | input | 3 | Current day of week |
| now_mday | input | 6 | Current date of month, BCD |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: 0-3 slot 1, 4-6 slot 2, 7 control, 8 status |
| reg_wdata | input | 8 | Register write data |
| sqw_in | input | 1 | Square wave from the divider |
| alarm1_flag | output | 1 | Sticky flag of slot 1 |
| alarm2_flag | output | 1 | Sticky flag of slot 2 |
| irq_drive | output | 1 | Open-drain pull-low enable of the shared pin |
| sqw_rate | output | 2 | Square-wave rate select to the divider |

## Verification
The bench builds the block with its default parameters: two slots, one with a seconds register and one without, and a 2-bit rate field. At this size the whole mask space of each slot can be swept against every pattern of matching and non-matching fields. That is 16 by 16 cases for slot 1 and 8 by 16 for slot 2, with the seconds-equal-zero condition included. The output pin is also swept over all 64 combinations of both flags, both enables, the mode bit and the square-wave level.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 7;
  localparam int WDAY_W = 3;
  localparam int MDAY_W = 6;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 4;
  localparam int N_ALARM = 2;
  localparam int RATE_W = 2;

  localparam logic [ADDR_W-1:0] A_SLOT1 = 4'd0;
  localparam logic [ADDR_W-1:0] A_SLOT2 = 4'd4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd7;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd8;

  localparam int MASK_BIT = 7;
  localparam int DAYSEL_BIT = 6;
  localparam int CTRL_MODE_BIT = 2;
  localparam int CTRL_RATE_LO = 3;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [MIN_W-1:0]  min;
    logic [HOUR_W-1:0] hour;
    logic [WDAY_W-1:0] wday;
    logic [MDAY_W-1:0] mday;
  } tod_t;
endpackage

// File: rtl/tod_alarm_slot.sv
module tod_alarm_slot
  import tod_alarm_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1,
  parameter logic [ADDR_W-1:0] BASE = 4'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  tod_t              now,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic              hit
);
  localparam int NREG = HAS_SEC ? 4 : 3;
  localparam int SKIP = HAS_SEC ? 0 : 1;

  logic [REG_W-1:0] fld_q [4];
  logic [ADDR_W:0]  off;
  logic             in_range;

  assign off      = {1'b0, addr} - {1'b0, BASE};
  assign in_range = (addr >= BASE) && (off < (ADDR_W+1)'(NREG));

  for (genvar k = 0; k < 4; k++) begin : g_fld
    if (k < SKIP) begin : g_absent
      assign fld_q[k] = '0;
    end else begin : g_reg
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (we && in_range && (off == (ADDR_W+1)'(k - SKIP))) q <= wdata;
      end
      assign fld_q[k] = q;
    end
  end

  logic sec_ok, min_ok, hour_ok, dd_ok;
  logic [MDAY_W-1:0] dd_target;

  always_comb begin
    if (HAS_SEC)
      sec_ok = fld_q[0][MASK_BIT] || (fld_q[0][SEC_W-1:0] == now.sec);
    else
      sec_ok = (now.sec == '0);
    min_ok  = fld_q[1][MASK_BIT] || (fld_q[1][MIN_W-1:0] == now.min);
    hour_ok = fld_q[2][MASK_BIT] || (fld_q[2][HOUR_W-1:0] == now.hour);
    dd_target = fld_q[3][DAYSEL_BIT] ? MDAY_W'(now.wday) : now.mday;
    dd_ok   = fld_q[3][MASK_BIT] || (fld_q[3][MDAY_W-1:0] == dd_target);
  end

  assign hit = tick && sec_ok && min_ok && hour_ok && dd_ok;
endmodule

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_alarm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_ALARM-1:0] hit,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic               sqw_in,
  output logic [N_ALARM-1:0] flag,
  output logic               irq_drive,
  output logic [RATE_W-1:0]  rate
);
  logic               mode_q;
  logic [N_ALARM-1:0] ie_q;
  logic [RATE_W-1:0]  rate_q;
  logic               ctrl_we, stat_we;

  assign ctrl_we = we && (addr == A_CTRL);
  assign stat_we = we && (addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
      ie_q   <= '0;
      rate_q <= '1;
    end else if (ctrl_we) begin
      mode_q <= wdata[CTRL_MODE_BIT];
      ie_q   <= wdata[N_ALARM-1:0];
      rate_q <= wdata[CTRL_RATE_LO +: RATE_W];
    end
  end

  for (genvar i = 0; i < N_ALARM; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else if (hit[i]) q <= 1'b1;
      else if (stat_we && !wdata[i]) q <= 1'b0;
    end
    assign flag[i] = q;

    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> flag[i]);
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |-> $past(stat_we && !wdata[i]));
    p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> $past(hit[i]));
  end

  assign irq_drive = mode_q ? |(flag & ie_q) : !sqw_in;
  assign rate      = rate_q;

  p_pin_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && (flag == '0)) |-> !irq_drive);
  p_pin_sqw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && $stable(sqw_in) && $stable(mode_q)) |-> $stable(irq_drive));
endmodule

// File: rtl/tod_alarm_pair.sv
module tod_alarm_pair
  import tod_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [SEC_W-1:0]  now_sec,
  input  logic [MIN_W-1:0]  now_min,
  input  logic [HOUR_W-1:0] now_hour,
  input  logic [WDAY_W-1:0] now_wday,
  input  logic [MDAY_W-1:0] now_mday,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              sqw_in,
  output logic              alarm1_flag,
  output logic              alarm2_flag,
  output logic              irq_drive,
  output logic [RATE_W-1:0] sqw_rate
);
  tod_t               now;
  logic [N_ALARM-1:0] hit;
  logic [N_ALARM-1:0] flag;

  assign now = '{sec: now_sec, min: now_min, hour: now_hour,
                 wday: now_wday, mday: now_mday};

  for (genvar i = 0; i < N_ALARM; i++) begin : g_slot
    tod_alarm_slot #(
      .HAS_SEC (i == 0),
      .BASE    (i == 0 ? A_SLOT1 : A_SLOT2)
    ) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .now   (now),
      .we    (reg_we),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .hit   (hit[i])
    );
  end

  tod_alarm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .sqw_in    (sqw_in),
    .flag      (flag),
    .irq_drive (irq_drive),
    .rate      (sqw_rate)
  );

  assign alarm1_flag = flag[0];
  assign alarm2_flag = flag[1];

  p_tick_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (alarm1_flag <= $past(alarm1_flag)) && (alarm2_flag <= $past(alarm2_flag)));
endmodule

// File: tb/tod_alarm_pair_tb.sv
module tod_alarm_pair_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] now_sec = '0, now_min = '0, now_hour = '0;
  logic [2:0] now_wday = '0;
  logic [5:0] now_mday = '0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       sqw_in = 1'b0;
  logic       alarm1_flag, alarm2_flag, irq_drive;
  logic [1:0] sqw_rate;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tod_alarm_pair u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_wday(now_wday), .now_mday(now_mday),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .sqw_in(sqw_in), .alarm1_flag(alarm1_flag), .alarm2_flag(alarm2_flag),
    .irq_drive(irq_drive), .sqw_rate(sqw_rate)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_time(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                          input logic [2:0] wd, input logic [5:0] md);
    now_sec = s; now_min = m; now_hour = h; now_wday = wd; now_mday = md;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 flag1", alarm1_flag, 0);
    chk("R10 flag2", alarm2_flag, 0);
    chk("R10 rate", sqw_rate, 3);
    chk("R10 pin", irq_drive, 0);
    sqw_in = 1'b1; #1;
    chk("R10 mode is interrupt", irq_drive, 0);
    sqw_in = 1'b0; #1;
    chk("R10 enables off", irq_drive, 0);

    // R1/R2 slot 1 sweep: stored sec 30, min 15, hour 08, date 12
    for (int m = 0; m < 16; m++) begin
      wr(4'd0, {m[0], 7'h30});
      wr(4'd1, {m[1], 7'h15});
      wr(4'd2, {m[2], 7'h08});
      wr(4'd3, {m[3], 7'h12});
      for (int t = 0; t < 16; t++) begin
        wr(4'd8, 8'h00);
        set_time(t[0] ? 7'h30 : 7'h31, t[1] ? 7'h15 : 7'h16,
                 t[2] ? 7'h08 : 7'h09, 3'd3, t[3] ? 6'h12 : 6'h13);
        pulse_tick();
        if (m == 0) chk("R1 exact match", alarm1_flag, (t == 15) ? 1 : 0);
        else        chk("R2 masked match", alarm1_flag, ((m | t) == 15) ? 1 : 0);
      end
    end

    // R3 slot 2 sweep: stored min 42, hour 17, date 05
    for (int m = 0; m < 8; m++) begin
      wr(4'd4, {m[0], 7'h42});
      wr(4'd5, {m[1], 7'h17});
      wr(4'd6, {m[2], 7'h05});
      for (int t = 0; t < 16; t++) begin
        wr(4'd8, 8'h00);
        set_time(t[0] ? 7'h00 : 7'h45, t[1] ? 7'h42 : 7'h43,
                 t[2] ? 7'h17 : 7'h18, 3'd1, t[3] ? 6'h05 : 6'h06);
        pulse_tick();
        chk("R3 slot2 match", alarm2_flag,
            (t[0] && ((m | (t >> 1)) == 7)) ? 1 : 0);
      end
    end

    // R4 day versus date
    wr(4'd0, 8'h80); wr(4'd1, 8'h80); wr(4'd2, 8'h80);
    wr(4'd3, 8'h44);
    wr(4'd8, 8'h00); set_time(7'h10, 7'h10, 7'h10, 3'd4, 6'h10); pulse_tick();
    chk("R4 day select hit", alarm1_flag, 1);
    wr(4'd8, 8'h00); set_time(7'h10, 7'h10, 7'h10, 3'd2, 6'h04); pulse_tick();
    chk("R4 day select ignores date", alarm1_flag, 0);
    wr(4'd3, 8'h04);
    wr(4'd8, 8'h00); set_time(7'h10, 7'h10, 7'h10, 3'd4, 6'h10); pulse_tick();
    chk("R4 date select ignores day", alarm1_flag, 0);
    wr(4'd8, 8'h00); set_time(7'h10, 7'h10, 7'h10, 3'd2, 6'h04); pulse_tick();
    chk("R4 date select hit", alarm1_flag, 1);

    // R5 no tick, all masked slots
    wr(4'd3, 8'h80);
    wr(4'd4, 8'h80); wr(4'd5, 8'h80); wr(4'd6, 8'h80);
    wr(4'd8, 8'h00);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      set_time(7'(k), 7'(k), 7'(k), 3'(k), 6'(k));
    end
    @(negedge clk);
    chk("R5 flag1 no tick", alarm1_flag, 0);
    chk("R5 flag2 no tick", alarm2_flag, 0);

    // R7 hit wins over simultaneous clear
    set_time(7'h00, 7'h00, 7'h00, 3'd1, 6'h01);
    @(negedge clk);
    tick = 1'b1; reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = 8'h00;
    @(negedge clk);
    tick = 1'b0; reg_we = 1'b0;
    chk("R7 set wins flag1", alarm1_flag, 1);
    chk("R7 set wins flag2", alarm2_flag, 1);

    // R6/R7/R8/R9 pin matrix
    for (int c = 0; c < 64; c++) begin
      set_time(7'h00, 7'h00, 7'h00, 3'd1, 6'h01);
      pulse_tick();
      chk("R6 flag1 set any control", alarm1_flag, 1);
      chk("R6 flag2 set any control", alarm2_flag, 1);
      wr(4'd8, {6'b0, c[1], c[0]});
      chk("R7 flag1 clear-only", alarm1_flag, c[0]);
      chk("R7 flag2 clear-only", alarm2_flag, c[1]);
      wr(4'd7, {3'b0, 2'b11, c[4], c[3], c[2]});
      sqw_in = c[5];
      #1;
      if (c[4]) chk("R8 interrupt pin", irq_drive, (c[0] & c[2]) | (c[1] & c[3]));
      else      chk("R9 square wave pin", irq_drive, c[5] ? 0 : 1);
    end

    // R11 rate field
    for (int r = 0; r < 4; r++) begin
      wr(4'd7, {3'b0, 2'(r), 3'b100});
      chk("R11 rate out", sqw_rate, r);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule